// File: doc/BRIEF.md
# SPI Interrupt Status and Mask Unit

This unit holds the seven-bit interrupt status of an SPI controller with transmit and receive FIFOs. It also holds the interrupt mask and drives one level-sensitive interrupt line. Three status bits latch events reported by the transfer engine: receive overrun, mode fault and transmit underrun. Software clears each of these by writing a 1 to it. The other four status bits follow the FIFOs in every cycle. Two of them repeat the FIFO full flags. The other two compare the fill counts against thresholds that software can program.

Software reaches the unit through a simple byte-addressed port. A write takes effect on a rising clock edge, and a read returns data combinationally for the address presented. The mask has no direct write. Software sets bits through one location and clears bits through another, so two agents can change different bits without a read-modify-write. The interrupt line is a register that sits behind the masked OR of the status bits.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the latched status bits are 0, the mask is 0, both thresholds are 1 and irq_o is 0.
- R2: A one-cycle pulse on ev_rx_ovf, ev_mode_fail or ev_tx_unf sets status bit 0, 1 or 6 respectively. The bit stays set until software clears it.
- R3: A write to the status location (0x04) clears each latched bit (0, 1, 6) whose write-data bit is 1. A write-data bit of 0 leaves its latched bit unchanged, and the write has no effect on bits 2 to 5.
- R4: When an event pulse and a clearing write for the same bit occur in the same cycle, the bit is set afterwards.
- R5: Status bit 5 equals rx_full and status bit 3 equals tx_full in the same cycle.
- R6: Status bit 4 is 1 exactly when rx_count is greater than or equal to the receive threshold.
- R7: Status bit 2 is 1 exactly when tx_count is strictly less than the transmit threshold.
- R8: A write to location 0x08 ORs write-data bits 6:0 into the mask. A write to 0x0C clears the mask bits whose write-data bit is 1. Location 0x10 reads the mask, and writes to it are ignored.
- R9: Locations 0x08 and 0x0C read as 0.
- R10: irq_o is 1 in the cycle after one in which (mask AND status) is non-zero, and 0 in the cycle after one in which it is zero.
- R11: The transmit threshold at 0x28 and the receive threshold at 0x2C are written from write-data bits CNT_W-1:0 and read back zero-extended. Status reads return bits 6:0 with all higher bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset of the accessed location |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| rx_count | input | CNT_W | Receive FIFO fill count |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| rx_full | input | 1 | Receive FIFO full flag |
| tx_full | input | 1 | Transmit FIFO full flag |
| ev_rx_ovf | input | 1 | Pulse: a received byte was dropped because the receive FIFO was full |
| ev_mode_fail | input | 1 | Pulse: mode fault detected |
| ev_tx_unf | input | 1 | Pulse: the transmit FIFO ran empty during a transfer |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that each event input is a clean single-cycle pulse and that reg_wr selects at most one location per cycle. Under these assumptions the mask's set and clear paths never collide. The bench drives every input on the falling clock edge and keeps each event high for exactly one cycle. It issues one register write at a time. The only overlap it creates on purpose is an event arriving together with a clearing write to the same status bit. Fill counts and full flags are held steady between samples, so each threshold comparison is observed in a quiet cycle.

// File: rtl/spi_irq_pkg.sv
// Shared constants for the SPI interrupt unit: the status bit positions,
// the register offsets and the set of latched (write-1-to-clear) bits.
// Assumes an 8-bit byte offset and a 32-bit data word.
package spi_irq_pkg;
    localparam int IRQ_W  = 7;
    localparam int DATA_W = 32;

    localparam int BIT_RX_OVF    = 0;
    localparam int BIT_MODE_FAIL = 1;
    localparam int BIT_TX_LOW    = 2;
    localparam int BIT_TX_FULL   = 3;
    localparam int BIT_RX_REACH  = 4;
    localparam int BIT_RX_FULL   = 5;
    localparam int BIT_TX_UNF    = 6;

    localparam logic [IRQ_W-1:0] LATCHED_BITS = IRQ_W'(
        (1 << BIT_RX_OVF) | (1 << BIT_MODE_FAIL) | (1 << BIT_TX_UNF));

    localparam logic [7:0] OFS_STATUS   = 8'h04;
    localparam logic [7:0] OFS_MASK_SET = 8'h08;
    localparam logic [7:0] OFS_MASK_CLR = 8'h0C;
    localparam logic [7:0] OFS_MASK     = 8'h10;
    localparam logic [7:0] OFS_TX_THR   = 8'h28;
    localparam logic [7:0] OFS_RX_THR   = 8'h2C;
endpackage

// File: rtl/spi_irq_thr_reg.sv
// One threshold register with a programmable reset value.
// Assumes the write enable is already qualified by the address decode.
module spi_irq_thr_reg #(
    parameter int               CNT_W   = 6,
    parameter logic [CNT_W-1:0] RST_VAL = CNT_W'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CNT_W-1:0] d,
    output logic [CNT_W-1:0] q
);
    // Load on write; return to RST_VAL on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_VAL;
        else if (we) q <= d;
    end

    // R11
    thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/spi_irq_mask.sv
// Interrupt mask that changes only through separate set and clear strobes.
// Assumes set_we and clr_we are never high together (distinct offsets).
module spi_irq_mask #(
    parameter int IRQ_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] wdata,
    output logic [IRQ_W-1:0] mask_q
);
    logic [IRQ_W-1:0] set_vec, clr_vec;

    // Qualify the write data with the set and clear strobes.
    always_comb begin
        set_vec = set_we ? wdata : '0;
        clr_vec = clr_we ? wdata : '0;
    end

    // Update the mask: OR in the set bits, then remove the clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q | set_vec) & ~clr_vec;
    end

    // R8
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((mask_q & $past(wdata)) == $past(wdata)));
    // R8
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((mask_q & $past(wdata)) == '0));
    // R8
    mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(mask_q));
endmodule

// File: rtl/spi_irq_status.sv
// Interrupt status vector. Latched bits are set by event pulses and cleared
// by write-1-to-clear; an event wins over a clear in the same cycle. Level
// bits are recomputed each cycle from the FIFO flags and fill counts.
// Assumes each event input is a single-cycle pulse from the transfer engine.
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] wdata,
    input  logic             ev_rx_ovf,
    input  logic             ev_mode_fail,
    input  logic             ev_tx_unf,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             rx_full,
    input  logic             tx_full,
    input  logic [CNT_W-1:0] rx_thr,
    input  logic [CNT_W-1:0] tx_thr,
    output logic [IRQ_W-1:0] status
);
    logic [IRQ_W-1:0] ev_vec, clr_vec, level_vec, latched_q;

    // Place the event pulses and the clear strobes at their bit positions.
    always_comb begin
        ev_vec                = '0;
        ev_vec[BIT_RX_OVF]    = ev_rx_ovf;
        ev_vec[BIT_MODE_FAIL] = ev_mode_fail;
        ev_vec[BIT_TX_UNF]    = ev_tx_unf;
        clr_vec               = clr_we ? wdata : '0;
    end

    // Compute the level bits from the live FIFO state.
    always_comb begin
        level_vec               = '0;
        level_vec[BIT_RX_FULL]  = rx_full;
        level_vec[BIT_TX_FULL]  = tx_full;
        level_vec[BIT_RX_REACH] = (rx_count >= rx_thr);
        level_vec[BIT_TX_LOW]   = (tx_count < tx_thr);
    end

    // Keep the latched bits; a new event overrides a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) latched_q <= '0;
        else        latched_q <= ((latched_q & ~clr_vec) | ev_vec) & LATCHED_BITS;
    end

    // Merge the latched and level halves into the visible status.
    assign status = (latched_q & LATCHED_BITS) | (level_vec & ~LATCHED_BITS);

    // R2
    ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_ovf || ev_mode_fail || ev_tx_unf) |=>
        ((status & $past(ev_vec)) == $past(ev_vec)));
    // R3
    w1c_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((status & LATCHED_BITS & $past(wdata) & ~$past(ev_vec)) == '0));
    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((status & LATCHED_BITS & $past(status)) == ($past(status) & LATCHED_BITS)));
endmodule

// File: rtl/spi_irq_ctrl.sv
// Top of the SPI interrupt unit: address decode, readback mux, and the
// registered interrupt line driven by the masked status.
// Assumes reg_wr writes a single location per cycle; reads are combinational.
module spi_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic              rx_full,
    input  logic              tx_full,
    input  logic              ev_rx_ovf,
    input  logic              ev_mode_fail,
    input  logic              ev_tx_unf,
    output logic              irq_o
);
    logic             we_status, we_set, we_clr, we_txthr, we_rxthr;
    logic [IRQ_W-1:0] mask_q, status;
    logic [CNT_W-1:0] tx_thr, rx_thr;
    logic             unused_wdata;

    // Decode the write strobe by offset.
    always_comb begin
        we_status = reg_wr && (reg_addr == OFS_STATUS);
        we_set    = reg_wr && (reg_addr == OFS_MASK_SET);
        we_clr    = reg_wr && (reg_addr == OFS_MASK_CLR);
        we_txthr  = reg_wr && (reg_addr == OFS_TX_THR);
        we_rxthr  = reg_wr && (reg_addr == OFS_RX_THR);
    end

    assign unused_wdata = ^reg_wdata;

    spi_irq_mask #(.IRQ_W(IRQ_W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (we_set),
        .clr_we (we_clr),
        .wdata  (reg_wdata[IRQ_W-1:0]),
        .mask_q (mask_q)
    );

    spi_irq_thr_reg #(.CNT_W(CNT_W), .RST_VAL(CNT_W'(1))) u_tx_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_txthr),
        .d     (reg_wdata[CNT_W-1:0]),
        .q     (tx_thr)
    );

    spi_irq_thr_reg #(.CNT_W(CNT_W), .RST_VAL(CNT_W'(1))) u_rx_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_rxthr),
        .d     (reg_wdata[CNT_W-1:0]),
        .q     (rx_thr)
    );

    spi_irq_status #(.CNT_W(CNT_W)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_we       (we_status),
        .wdata        (reg_wdata[IRQ_W-1:0]),
        .ev_rx_ovf    (ev_rx_ovf),
        .ev_mode_fail (ev_mode_fail),
        .ev_tx_unf    (ev_tx_unf),
        .rx_count     (rx_count),
        .tx_count     (tx_count),
        .rx_full      (rx_full),
        .tx_full      (tx_full),
        .rx_thr       (rx_thr),
        .tx_thr       (tx_thr),
        .status       (status)
    );

    // Return the addressed location; write-only and unknown offsets read 0.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STATUS: reg_rdata[IRQ_W-1:0] = status;
            OFS_MASK:   reg_rdata[IRQ_W-1:0] = mask_q;
            OFS_TX_THR: reg_rdata[CNT_W-1:0] = tx_thr;
            OFS_RX_THR: reg_rdata[CNT_W-1:0] = rx_thr;
            default:    reg_rdata = '0;
        endcase
    end

    // Register the masked OR of the status as the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(mask_q & status);
    end

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(mask_q & status)) |=> irq_o);
    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(mask_q & status)) |=> !irq_o);
endmodule

// File: tb/spi_irq_ctrl_bench.sv
`timescale 1ns/1ps
module spi_irq_ctrl_bench;
    localparam int CNT_W = 6;
    localparam logic [7:0] A_STATUS = 8'h04, A_SET = 8'h08, A_CLR = 8'h0C,
                           A_MASK = 8'h10, A_TXT = 8'h28, A_RXT = 8'h2C;

    // {rx_thr, tx_thr, rx_count, tx_count, rx_full, tx_full, expected status}
    localparam int NV = 10;
    localparam logic [32:0] VEC [NV] = '{
        {6'd1,  6'd1,  6'd0,  6'd0,  1'b0, 1'b0, 7'h04},
        {6'd1,  6'd1,  6'd1,  6'd1,  1'b0, 1'b0, 7'h10},
        {6'd8,  6'd8,  6'd7,  6'd7,  1'b0, 1'b0, 7'h04},
        {6'd8,  6'd8,  6'd8,  6'd8,  1'b0, 1'b0, 7'h10},
        {6'd8,  6'd8,  6'd9,  6'd9,  1'b0, 1'b0, 7'h10},
        {6'd32, 6'd32, 6'd32, 6'd32, 1'b1, 1'b1, 7'h38},
        {6'd32, 6'd32, 6'd31, 6'd31, 1'b0, 1'b0, 7'h04},
        {6'd0,  6'd0,  6'd0,  6'd0,  1'b0, 1'b0, 7'h10},
        {6'd63, 6'd1,  6'd5,  6'd0,  1'b1, 1'b0, 7'h24},
        {6'd2,  6'd5,  6'd3,  6'd4,  1'b0, 1'b1, 7'h1C}
    };

    logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [CNT_W-1:0] rx_count = '0, tx_count = '0;
    logic rx_full = 1'b0, tx_full = 1'b0;
    logic ev_rx_ovf = 1'b0, ev_mode_fail = 1'b0, ev_tx_unf = 1'b0;
    logic irq_o;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spi_irq_ctrl #(.CNT_W(CNT_W)) u_spi_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_count(rx_count),
        .tx_count(tx_count), .rx_full(rx_full), .tx_full(tx_full),
        .ev_rx_ovf(ev_rx_ovf), .ev_mode_fail(ev_mode_fail),
        .ev_tx_unf(ev_tx_unf), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        do_reset();
        // R1: reset values (tx_count 0 < threshold 1 shows in bit 2)
        rd(A_STATUS, r); check("R1 status", r, 32'h04);
        rd(A_MASK, r);   check("R1 mask", r, 32'h0);
        rd(A_TXT, r);    check("R1 tx thr", r, 32'h1);
        rd(A_RXT, r);    check("R1 rx thr", r, 32'h1);
        check("R1 irq", {31'b0, irq_o}, 32'h0);

        // R5 R6 R7 R11: level bits across the table
        for (int i = 0; i < NV; i++) begin
            wr(A_RXT, {26'b0, VEC[i][32:27]});
            wr(A_TXT, {26'b0, VEC[i][26:21]});
            rx_count = VEC[i][20:15]; tx_count = VEC[i][14:9];
            rx_full = VEC[i][8]; tx_full = VEC[i][7];
            rd(A_STATUS, r); check("R5/R6/R7 status vector", r, {25'b0, VEC[i][6:0]});
            rd(A_RXT, r);    check("R11 rx thr readback", r, {26'b0, VEC[i][32:27]});
            rd(A_TXT, r);    check("R11 tx thr readback", r, {26'b0, VEC[i][26:21]});
        end

        wr(A_RXT, 32'h1); wr(A_TXT, 32'h1);
        @(negedge clk);
        rx_count = '0; tx_count = 6'd3; rx_full = 1'b0; tx_full = 1'b0;
        rd(A_STATUS, r); check("R6/R7 quiet", r, 32'h0);

        // R2: latched event and hold
        @(negedge clk); ev_rx_ovf = 1'b1; @(negedge clk); ev_rx_ovf = 1'b0;
        rd(A_STATUS, r); check("R2 rx ovf set", r, 32'h01);
        repeat (3) @(negedge clk);
        rd(A_STATUS, r); check("R2 rx ovf held", r, 32'h01);
        // R3: clear only written bits
        wr(A_STATUS, 32'h02);
        rd(A_STATUS, r); check("R3 other bit untouched", r, 32'h01);
        wr(A_STATUS, 32'h01);
        rd(A_STATUS, r); check("R3 cleared", r, 32'h00);
        @(negedge clk); ev_mode_fail = 1'b1; @(negedge clk); ev_mode_fail = 1'b0;
        rd(A_STATUS, r); check("R2 mode fail set", r, 32'h02);
        wr(A_STATUS, 32'h02);

        // R4: event beats same-cycle clear
        @(negedge clk); ev_tx_unf = 1'b1; @(negedge clk); ev_tx_unf = 1'b0;
        rd(A_STATUS, r); check("R2 tx unf set", r, 32'h40);
        @(negedge clk);
        ev_tx_unf = 1'b1; reg_wr = 1'b1; reg_addr = A_STATUS; reg_wdata = 32'h40;
        @(negedge clk);
        ev_tx_unf = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        rd(A_STATUS, r); check("R4 event wins", r, 32'h40);
        wr(A_STATUS, 32'h40);
        rd(A_STATUS, r); check("R3 tx unf cleared", r, 32'h00);

        // R3: level bit not cleared by write
        @(negedge clk); rx_full = 1'b1;
        wr(A_STATUS, 32'h7F);
        rd(A_STATUS, r); check("R3/R5 level bit kept", r, 32'h20);
        rx_full = 1'b0;

        // R8 R9: mask access
        wr(A_MASK, 32'h7F);
        rd(A_MASK, r); check("R8 direct write ignored", r, 32'h00);
        wr(A_SET, 32'h41); rd(A_MASK, r); check("R8 set", r, 32'h41);
        wr(A_SET, 32'h02); rd(A_MASK, r); check("R8 set ORs", r, 32'h43);
        wr(A_CLR, 32'h01); rd(A_MASK, r); check("R8 clear", r, 32'h42);
        rd(A_SET, r); check("R9 set loc reads 0", r, 32'h0);
        rd(A_CLR, r); check("R9 clear loc reads 0", r, 32'h0);
        wr(A_CLR, 32'h7F); rd(A_MASK, r); check("R8 clear all", r, 32'h00);

        // R10: registered irq from a latched bit
        wr(A_SET, 32'h02);
        check("R10 irq idle", {31'b0, irq_o}, 32'h0);
        @(negedge clk); ev_mode_fail = 1'b1; @(negedge clk); ev_mode_fail = 1'b0;
        check("R10 irq one cycle late", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R10 irq rises", {31'b0, irq_o}, 32'h1);
        wr(A_CLR, 32'h02);
        check("R10 irq lags mask", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        check("R10 irq falls", {31'b0, irq_o}, 32'h0);
        wr(A_STATUS, 32'h02);

        // R10 R5: level bit drives irq
        wr(A_SET, 32'h20);
        rx_full = 1'b1;
        @(negedge clk);
        check("R10/R5 irq from rx full", {31'b0, irq_o}, 32'h1);
        rx_full = 1'b0;
        @(negedge clk);
        check("R10/R5 irq drops", {31'b0, irq_o}, 32'h0);
        wr(A_CLR, 32'h20);

        // R7 R10: raising the tx threshold above the count
        wr(A_SET, 32'h04);
        wr(A_TXT, 32'h4);
        check("R7 irq after threshold write", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R7 irq from tx low", {31'b0, irq_o}, 32'h1);

        // R1: reset mid-run
        do_reset();
        rd(A_MASK, r);   check("R1 mask after reset", r, 32'h0);
        rd(A_TXT, r);    check("R1 tx thr after reset", r, 32'h1);
        rd(A_STATUS, r); check("R1 status after reset", r, 32'h0);
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule